// File: doc/BRIEF.md
# Sixteen-Source Prioritized Interrupt Controller

This block collects sixteen request lines from neighbouring peripheral logic and presents one interrupt request to a processor. Each source owns one bit in four 16-bit registers: enable, pending, in-service and mask. Software reaches them over a byte-wide register bus, one byte per address. The upper half covers sources 15..8 and the lower half covers sources 7..0. A rising edge on an enabled source line latches a pending bit. The pending source of highest number that is also unmasked raises the request, unless a source of equal or higher priority is already in service.

When the processor acknowledges, the block presents a vector. The vector is a programmable upper nibble followed by the 4-bit number of the winning source. The acknowledge retires that source's pending bit. A mode bit in the vector register picks how interrupts end. In software end-of-interrupt mode the acknowledged source is marked in service until software clears it. In automatic mode nothing is marked.

Pending and in-service bits never clear by themselves. Software clears them by writing a byte that is ANDed into the register. Rewriting the enable or mask register also removes any pending or in-service bits that are no longer allowed.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable, pending, in-service, mask and vector registers all read 0 and `irq` is low.
- R2: A rising edge on `src_in[i]` sets pending bit i one cycle later, but only if enable bit i is set. A line held high sets nothing further, and an edge on a disabled source is lost.
- R3: A write to address 0 replaces enable bits 15:8, and a write to address 1 replaces enable bits 7:0. Any pending bit whose enable is 0 after the write is cleared in the same cycle.
- R4: A write to address 2 (bits 15:8) or address 3 (bits 7:0) ANDs the byte into the pending register. A 0 clears the bit and a 1 leaves it as it was.
- R5: A write to address 4 (bits 15:8) or address 5 (bits 7:0) ANDs the byte into the in-service register, so it can only clear bits.
- R6: A write to address 6 replaces mask bits 15:8, and a write to address 7 replaces mask bits 7:0. Any in-service bit whose mask is 0 afterwards is cleared. A pending bit with mask 0 never raises `irq`.
- R7: Address 8 is the vector register, and it keeps only bits 7:3 of the written byte (bits 2:0 read 0). Bit 3 set selects software end-of-interrupt. Writing it with bit 3 clear selects automatic mode and clears the whole in-service register.
- R8: `irq` is high exactly when some bit of (pending AND mask) has a higher index than every set in-service bit. Bit 15 has the highest priority.
- R9: While `irq` is high, `vec_out` equals the vector register's bits 7:4 followed by the index of the highest-priority pending unmasked source.
- R10: `ack` sampled with `irq` high clears the winning pending bit. It sets that source's in-service bit only in software end-of-interrupt mode. `ack` with `irq` low has no effect.
- R11: `rdata` combinationally returns the register at `addr`, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for `addr` |
| src_in | input | 16 | Source request lines, rising-edge sensitive |
| ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| vec_out | output | 8 | Vector for the current winner |

## Verification
A wrong bit in the pending or in-service register shows up in one of two ways. It shows on `irq` or `vec_out` in the same cycle the wrong bit changes who wins. It also shows on `rdata` the first time that register half is addressed. A missed prune after an enable or mask write only becomes visible later. It can leave an orphan bit that raises a request or blocks one, so the bench compares the read-back on every clock. This catches the error in the cycle after the faulty write rather than at the next acknowledge.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants, register address map and half-register
// update helpers for the prioritized interrupt controller.
// Assumes 16 sources split into two byte halves.
package irq_ctrl_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned NSRC    = 2 * BYTE_W;
    localparam int unsigned IDX_W   = $clog2(NSRC);
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned SOFT_EOI_BIT = 3;
    localparam logic [BYTE_W-1:0] VEC_KEEP = 8'hF8;

    typedef enum logic [ADDR_W-1:0] {
        RA_EN_HI  = 4'd0,
        RA_EN_LO  = 4'd1,
        RA_PND_HI = 4'd2,
        RA_PND_LO = 4'd3,
        RA_SVC_HI = 4'd4,
        RA_SVC_LO = 4'd5,
        RA_MSK_HI = 4'd6,
        RA_MSK_LO = 4'd7,
        RA_VEC    = 4'd8
    } reg_addr_e;

    // Replace one byte half of a 16-bit register.
    function automatic logic [NSRC-1:0] put_half(input logic [NSRC-1:0] cur,
                                                 input logic [BYTE_W-1:0] b,
                                                 input logic hi);
        logic [NSRC-1:0] r;
        r = cur;
        if (hi) r[NSRC-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]    = b;
        return r;
    endfunction

    // Build an AND mask that touches only one byte half.
    function automatic logic [NSRC-1:0] and_half(input logic [BYTE_W-1:0] b,
                                                 input logic hi);
        logic [NSRC-1:0] r;
        r = '1;
        if (hi) r[NSRC-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]    = b;
        return r;
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
// Module: irq_edge_det
// Turns level request lines into one-cycle rise pulses.
// Assumes inputs are already synchronous to clk; the line history
// resets to 0, so a line high at reset release counts as a rise.
module irq_edge_det #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    // Record last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

endmodule

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Finds the highest set bit of a request vector.
// Assumes higher index means higher priority; idx is 0 when nothing is set.
module irq_prio_enc #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan upward so the last hit, the highest index, wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl
// Sixteen-source prioritized interrupt controller with enable, pending,
// in-service and mask registers written as byte halves, a vector register
// with a software/automatic end-of-interrupt bit, and an acknowledge port.
// Assumes one register write per cycle and a synchronous acknowledge pulse.
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic [NSRC-1:0]     src_in,
    input  logic                ack,
    output logic                irq,
    output logic [BYTE_W-1:0]   vec_out
);

    logic [NSRC-1:0]   en_q, pnd_q, svc_q, msk_q;
    logic [BYTE_W-1:0] vec_q;
    logic [NSRC-1:0]   en_d, pnd_d, svc_d, msk_d;
    logic [BYTE_W-1:0] vec_d;
    logic [NSRC-1:0]   rise, pnd_keep, svc_keep, ack_bit;
    logic              pm_found, svc_found, take, soft_eoi;
    logic [IDX_W-1:0]  pm_idx, svc_idx;

    irq_edge_det #(.N(NSRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(src_in), .rise(rise)
    );

    irq_prio_enc #(.N(NSRC)) u_pm_enc (
        .req(pnd_q & msk_q), .found(pm_found), .idx(pm_idx)
    );

    irq_prio_enc #(.N(NSRC)) u_svc_enc (
        .req(svc_q), .found(svc_found), .idx(svc_idx)
    );

    assign soft_eoi = vec_q[SOFT_EOI_BIT];

    // Request when the best pending unmasked source outranks all in service.
    assign irq     = pm_found && (!svc_found || (pm_idx > svc_idx));
    assign vec_out = {vec_q[BYTE_W-1:IDX_W], pm_idx};
    assign take    = ack && irq;
    assign ack_bit = take ? (NSRC'(1) << pm_idx) : '0;

    // Decode register writes into replacement values and AND masks.
    always_comb begin
        en_d     = en_q;
        msk_d    = msk_q;
        vec_d    = vec_q;
        pnd_keep = '1;
        svc_keep = '1;
        if (wr_en) begin
            case (addr)
                RA_EN_HI:  en_d     = put_half(en_q, wdata, 1'b1);
                RA_EN_LO:  en_d     = put_half(en_q, wdata, 1'b0);
                RA_PND_HI: pnd_keep = and_half(wdata, 1'b1);
                RA_PND_LO: pnd_keep = and_half(wdata, 1'b0);
                RA_SVC_HI: svc_keep = and_half(wdata, 1'b1);
                RA_SVC_LO: svc_keep = and_half(wdata, 1'b0);
                RA_MSK_HI: msk_d    = put_half(msk_q, wdata, 1'b1);
                RA_MSK_LO: msk_d    = put_half(msk_q, wdata, 1'b0);
                RA_VEC: begin
                    vec_d = wdata & VEC_KEEP;
                    if (!wdata[SOFT_EOI_BIT]) svc_keep = '0;
                end
                default: ;
            endcase
        end
    end

    // Pending: set by enabled rises, cleared by ack, CPU AND and enable prune.
    assign pnd_d = ((pnd_q | (rise & en_q)) & ~ack_bit) & pnd_keep & en_d;

    // In-service: set by ack in software mode, cleared by CPU AND and mask prune.
    assign svc_d = (svc_q | (soft_eoi ? ack_bit : '0)) & svc_keep & msk_d;

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pnd_q <= '0;
            svc_q <= '0;
            msk_q <= '0;
            vec_q <= '0;
        end else begin
            en_q  <= en_d;
            pnd_q <= pnd_d;
            svc_q <= svc_d;
            msk_q <= msk_d;
            vec_q <= vec_d;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (addr)
            RA_EN_HI:  rdata = en_q[NSRC-1:BYTE_W];
            RA_EN_LO:  rdata = en_q[BYTE_W-1:0];
            RA_PND_HI: rdata = pnd_q[NSRC-1:BYTE_W];
            RA_PND_LO: rdata = pnd_q[BYTE_W-1:0];
            RA_SVC_HI: rdata = svc_q[NSRC-1:BYTE_W];
            RA_SVC_LO: rdata = svc_q[BYTE_W-1:0];
            RA_MSK_HI: rdata = msk_q[NSRC-1:BYTE_W];
            RA_MSK_LO: rdata = msk_q[BYTE_W-1:0];
            RA_VEC:    rdata = vec_q;
            default:   rdata = '0;
        endcase
    end

    // R3: no pending bit survives without its enable.
    a_r3_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pnd_q & ~en_q) == '0);

    // R6: no in-service bit survives without its mask.
    a_r6_svc_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_q & ~msk_q) == '0);

    // R7: automatic-mode vector write empties in-service.
    a_r7_auto_clears_svc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_VEC && !wdata[SOFT_EOI_BIT]) |=> svc_q == '0);

    // R8: a raised request always points at a pending, unmasked source.
    a_r8_irq_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pnd_q[pm_idx] && msk_q[pm_idx]));

    // R10: acknowledged source is no longer pending.
    a_r10_ack_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> !pnd_q[$past(pm_idx)]);

    // R10: automatic mode never adds in-service bits.
    a_r10_auto_no_new_svc: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_eoi |=> (svc_q & ~$past(svc_q)) == '0);

endmodule

// File: tb/sim_prio_irq_ctrl.sv
// Bench: behavioural reference model of the interrupt controller compared
// against the ports on every clock.
module sim_prio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] src_in = '0;
    logic        ack = 1'b0;
    logic        irq;
    logic [7:0]  vec_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    string phase = "R1";

    // reference state
    bit [15:0] m_en, m_pnd, m_svc, m_msk, m_prev;
    bit [7:0]  m_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_in(src_in), .ack(ack), .irq(irq), .vec_out(vec_out)
    );

    function automatic int top_bit(input bit [15:0] v);
        int r = -1;
        for (int i = 0; i < 16; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic bit m_irq();
        int p = top_bit(m_pnd & m_msk);
        int s = top_bit(m_svc);
        return (p >= 0) && (p > s);
    endfunction

    function automatic bit [7:0] m_read(input bit [3:0] a);
        case (a)
            0: return m_en[15:8];
            1: return m_en[7:0];
            2: return m_pnd[15:8];
            3: return m_pnd[7:0];
            4: return m_svc[15:8];
            5: return m_svc[7:0];
            6: return m_msk[15:8];
            7: return m_msk[7:0];
            8: return m_vec;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_for(input bit [3:0] a);
        case (a)
            0, 1: return "R3";
            2, 3: return "R4";
            4, 5: return "R5";
            6, 7: return "R6";
            8:    return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s/%s %s: actual %h expected %h", tag, phase, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, compare ports, then advance the model.
    task automatic step(input bit w, input bit [3:0] a, input bit [7:0] d,
                        input bit [15:0] s, input bit k);
        bit [15:0] rise, ackb, pkeep, skeep, en_n, msk_n;
        int p;
        bit take;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; src_in = s; ack = k;
        #1;
        check("R8", "irq", {15'd0, irq}, {15'd0, m_irq()});
        if (m_irq()) begin
            p = top_bit(m_pnd & m_msk);
            check("R9", "vec_out", {8'd0, vec_out}, {8'd0, m_vec[7:4], 4'(p)});
        end
        check(tag_for(a), "rdata", {8'd0, rdata}, {8'd0, m_read(a)});
        @(posedge clk);
        #1;
        // reference update (R2, R10 and the write rules)
        rise = s & ~m_prev;
        m_prev = s;
        take = k && m_irq();
        p = top_bit(m_pnd & m_msk);
        ackb = take ? (16'd1 << p) : 16'd0;
        en_n = m_en; msk_n = m_msk; pkeep = '1; skeep = '1;
        if (w) begin
            case (a)
                0: en_n[15:8] = d;
                1: en_n[7:0]  = d;
                2: pkeep[15:8] = d;
                3: pkeep[7:0]  = d;
                4: skeep[15:8] = d;
                5: skeep[7:0]  = d;
                6: msk_n[15:8] = d;
                7: msk_n[7:0]  = d;
                default: ;
            endcase
        end
        for (int i = 0; i < 16; i++) begin
            bit pb, sb;
            pb = m_pnd[i] | (rise[i] & m_en[i]);
            if (ackb[i]) pb = 0;
            if (!pkeep[i] || !en_n[i]) pb = 0;
            sb = m_svc[i] | (ackb[i] & m_vec[3]);
            if (!skeep[i] || !msk_n[i]) sb = 0;
            m_pnd[i] = pb;
            m_svc[i] = sb;
        end
        if (w && a == 8) begin
            if (!d[3]) m_svc = '0;
            m_vec = d & 8'hF8;
        end
        m_en = en_n;
        m_msk = msk_n;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit [15:0] s;
        m_en = 0; m_pnd = 0; m_svc = 0; m_msk = 0; m_prev = 0; m_vec = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every register reads zero after reset
        phase = "R1";
        for (int a = 0; a < 10; a++) step(0, 4'(a), 0, 0, 0);

        // R2: edge on disabled source is lost; enabled edges latch once
        phase = "R2";
        step(0, 3, 0, 16'h0008, 0);
        step(0, 3, 0, 16'h0000, 0);
        step(1, 1, 8'hFF, 0, 0);
        step(1, 0, 8'hFF, 0, 0);
        step(1, 7, 8'hFF, 0, 0);
        step(1, 6, 8'hFF, 0, 0);
        step(1, 8, 8'h5F, 0, 0);           // R7: soft mode, keeps 0x58
        step(0, 8, 0, 0, 0);
        step(0, 3, 0, 16'h0008, 0);
        step(0, 3, 0, 16'h0008, 0);        // held high: no new set
        step(0, 3, 0, 16'h0208, 0);        // source 9 wins (R8, R9)

        // R10: ack in soft mode marks source 9 in service
        phase = "R10";
        step(0, 2, 0, 16'h0208, 1);
        step(0, 4, 0, 16'h0208, 1);        // irq low: ack ignored
        step(0, 2, 0, 0, 0);
        step(1, 4, 8'hFD, 0, 0);           // R5: clear in-service 9
        step(0, 4, 0, 0, 0);

        // R6: masking a pending source hides it; mask prunes in-service
        phase = "R6";
        step(1, 7, 8'hF7, 0, 0);
        step(0, 7, 0, 0, 0);
        step(1, 7, 8'hFF, 0, 0);
        step(0, 3, 0, 0, 1);               // soft ack of source 3
        step(1, 7, 8'h00, 0, 0);
        step(0, 5, 0, 0, 0);

        // R7: automatic mode write clears in-service, ack sets none
        phase = "R7";
        step(1, 7, 8'hFF, 16'h8001, 0);
        step(0, 2, 0, 16'h8001, 1);
        step(0, 4, 0, 16'h8001, 1);
        step(1, 8, 8'hA0, 0, 0);
        step(0, 4, 0, 16'h0100, 0);
        step(0, 4, 0, 16'h0100, 1);
        step(0, 5, 0, 0, 1);

        // R3/R4: enable prune and AND-clear of pending
        phase = "R3";
        step(0, 0, 0, 16'h00F0, 0);
        step(1, 1, 8'h0F, 0, 0);
        step(0, 3, 0, 0, 0);
        phase = "R4";
        step(1, 1, 8'hFF, 16'h0FF0, 0);
        step(1, 3, 8'hBF, 0, 0);
        step(0, 3, 0, 0, 0);

        // mixed random traffic over all rules
        phase = "mix";
        s = 0;
        for (int n = 0; n < 6000; n++) begin
            bit w;
            bit [3:0] a;
            bit [7:0] d;
            w = ($urandom_range(0, 9) < 3);
            a = 4'($urandom_range(0, 9));
            d = 8'($urandom);
            if (a inside {[2:5]} && $urandom_range(0, 3) != 0) d = ~(8'd1 << $urandom_range(0, 7));
            if ((a == 0 || a == 1 || a == 6 || a == 7) && $urandom_range(0, 3) != 0) d = d | 8'hE7;
            if (a == 8 && $urandom_range(0, 3) != 0) d[3] = 1'b1;
            s = s ^ (16'(1) << $urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) s = s ^ 16'($urandom);
            step(w, a, d, s, ($urandom_range(0, 4) == 0));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule